// File: doc/BRIEF.md
# Configurable SPI Master Shifter

This block is a single-frame SPI master. The host sets four mode inputs (clock polarity, clock phase, frame width and bit order) and a clock divisor, places a word on the transmit input and pulses start. The block pulls the select line low and clocks out 8 or 16 bits on MOSI. It captures the same number of bits from MISO, releases the select line and then signals completion with a one-cycle pulse. The received word is then available on a parallel output.

The block latches every mode input and the transmit word in the cycle it accepts start. Changes on those inputs during a frame therefore have no effect on it. The serial clock runs at the system clock divided by 2×(divisor+1). The frame width and the bit order apply to both the transmit path and the receive path. In 8-bit frames the block uses only the low byte of the transmit word, and the received byte is zero-extended to 16 bits.

Top module: `spi_master_shifter`

## Requirements
- R1: After reset, nss_n is 1, sck is 0, busy is 0, done is 0 and rx_word is 0.
- R2: While nss_n is high, sck sits at the polarity latched for the latest frame: 0 when cfg_cpol was 0, 1 when it was 1. It is already at that level when nss_n rises.
- R3: A frame has exactly 2×N sck transitions, where N is 16 when cfg_wide is 1 and 8 when it is 0. The first transition comes cfg_div+1 system cycles after nss_n falls. Consecutive transitions are cfg_div+1 cycles apart. nss_n rises cfg_div+1 cycles after the last transition.
- R4: With cfg_cpha=0, MOSI carries the first bit from the cycle nss_n falls, and both sides sample on the first (leading) transition of each bit. With cfg_cpha=1, bits change on the leading transition and are sampled on the second (trailing) one.
- R5: With cfg_lsb_first=0, bits go out from the top bit of the frame (bit N-1) down to bit 0. The received bits fill rx_word in that same order, so the first bit received lands in bit N-1.
- R6: With cfg_lsb_first=1, bit 0 goes out first and the first bit received lands in rx_word bit 0.
- R7: With cfg_wide=0, exactly 8 bits are exchanged and only tx_word[7:0] is sent. rx_word[15:8] reads 0 even when the previous frame had filled them.
- R8: done is high for exactly one cycle, the cycle after nss_n rises, and rx_word holds the new frame from that cycle on. busy is high from the cycle after start is accepted and goes low in the same cycle that done goes high.
- R9: A start pulse that arrives while busy is high is ignored. The running frame completes unchanged and no second frame follows.
- R10: Changes to cfg_* or tx_word during a frame do not alter that frame's clocking, bit count, bit order or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a frame, taken only when idle |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_cpha | input | 1 | 0: sample on leading transition, 1: sample on trailing transition |
| cfg_wide | input | 1 | 1: 16-bit frame, 0: 8-bit frame |
| cfg_lsb_first | input | 1 | 1: bit 0 first, 0: top bit first |
| cfg_div | input | DIV_W | Half-period of sck in system cycles, minus one |
| tx_word | input | 16 | Word to transmit |
| rx_word | output | 16 | Last received word, zero-extended for 8-bit frames |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| nss_n | output | 1 | Active-low slave select |

## Verification
The bench runs a behavioural slave that decides on its own which sck transitions are capture transitions, based on polarity and phase. It runs all four clock modes, both bit orders and both widths. A design with leading and trailing transitions swapped, or with the bit index reversed, would hand the slave a scrambled word, and a design with an off-by-one edge count would clip or extend the frame. An 8-bit frame that directly follows a frame with a full upper byte would expose missing zero-extension. A mid-frame start pulse and mid-frame changes to the mode and divisor inputs would expose a design that re-latches, while cycle counts between select and clock transitions would catch a lead, trail or done pulse in the wrong cycle.

// File: rtl/spi_mstr_pkg.sv
package spi_mstr_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned POS_W  = $clog2(WORD_W);
    localparam int unsigned EDGE_W = $clog2(2 * WORD_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_STOP
    } seq_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic wide;
        logic lsb_first;
    } mode_t;

    // Maps the n-th bit on the wire to its position in the data word.
    function automatic logic [POS_W-1:0] bit_pos(input logic wide,
                                                 input logic lsb_first,
                                                 input logic [POS_W-1:0] idx);
        logic [POS_W-1:0] top;
        top = wide ? POS_W'(WORD_W - 1) : POS_W'(BYTE_W - 1);
        return lsb_first ? idx : (top - idx);
    endfunction

    // Number of sck transitions in a frame of the selected width.
    function automatic logic [EDGE_W-1:0] edge_total(input logic wide);
        return wide ? EDGE_W'(2 * WORD_W) : EDGE_W'(2 * BYTE_W);
    endfunction

endpackage

// File: rtl/spi_mstr_divider.sv
module spi_mstr_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = (!run || tick) ? '0 : cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    half_period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div));

    // R3
    idle_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/spi_mstr_rxasm.sv
module spi_mstr_rxasm
    import spi_mstr_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 strobe,
    input  logic [$clog2(W)-1:0] pos,
    input  logic                 din,
    output logic [W-1:0]         acc
);

    logic [W-1:0] acc_d, acc_q;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (clear)                                   acc_d[i] = 1'b0;
            else if (strobe && (pos == $clog2(W)'(i)))   acc_d[i] = din;
            else                                         acc_d[i] = acc_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

    // R7
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0));

    // R5
    rx_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !clear) |=> ($countones(acc_q ^ $past(acc_q)) <= 1));

endmodule

// File: rtl/spi_master_shifter.sv
module spi_master_shifter
    import spi_mstr_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_wide,
    input  logic              cfg_lsb_first,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              busy,
    output logic              done,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              nss_n
);

    typedef struct packed {
        seq_e              state;
        mode_t             mode;
        logic [DIV_W-1:0]  div;
        logic [WORD_W-1:0] tx;
        logic [EDGE_W-1:0] edges;
        logic              sck;
        logic              mosi;
        logic              nss_n;
        logic              busy;
        logic              done;
        logic [WORD_W-1:0] rx;
    } regs_t;

    regs_t r_d, r_q;

    logic              tick;
    logic              run;
    logic [WORD_W-1:0] acc;
    logic              rx_clear;
    logic              rx_strobe;
    logic [POS_W-1:0]  rx_pos;

    logic [EDGE_W-1:0] edge_nx;
    logic [EDGE_W-1:0] edge_last;
    logic [EDGE_W-2:0] next_bit;
    logic [EDGE_W-2:0] frame_bits;
    logic              do_edge;
    logic              is_sample;

    assign run = (r_q.state == ST_LEAD) || (r_q.state == ST_SHIFT);

    spi_mstr_divider #(.DIV_W(DIV_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (r_q.div),
        .tick  (tick)
    );

    spi_mstr_rxasm #(.W(WORD_W)) i_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (rx_clear),
        .strobe (rx_strobe),
        .pos    (rx_pos),
        .din    (miso),
        .acc    (acc)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        rx_clear   = 1'b0;
        rx_strobe  = 1'b0;
        rx_pos     = '0;

        edge_nx    = r_q.edges + EDGE_W'(1);
        edge_last  = edge_total(r_q.mode.wide);
        next_bit   = edge_nx[EDGE_W-1:1];
        frame_bits = r_q.mode.wide ? (EDGE_W-1)'(WORD_W) : (EDGE_W-1)'(BYTE_W);
        // Odd transitions are leading ones; phase 0 samples there.
        is_sample  = edge_nx[0] ^ r_q.mode.cpha;
        do_edge    = tick && ((r_q.state == ST_LEAD) ||
                              ((r_q.state == ST_SHIFT) && (r_q.edges != edge_last)));

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state          = ST_LEAD;
                    r_d.mode.cpol      = cfg_cpol;
                    r_d.mode.cpha      = cfg_cpha;
                    r_d.mode.wide      = cfg_wide;
                    r_d.mode.lsb_first = cfg_lsb_first;
                    r_d.div            = cfg_div;
                    r_d.tx             = cfg_wide ? tx_word
                                                  : {{(WORD_W-BYTE_W){1'b0}}, tx_word[BYTE_W-1:0]};
                    r_d.edges          = '0;
                    r_d.sck            = cfg_cpol;
                    r_d.nss_n          = 1'b0;
                    r_d.busy           = 1'b1;
                    r_d.mosi           = tx_word[bit_pos(cfg_wide, cfg_lsb_first, '0)];
                    rx_clear           = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tick) r_d.state = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (tick && (r_q.edges == edge_last)) begin
                    r_d.nss_n = 1'b1;
                    r_d.state = ST_STOP;
                end
            end
            ST_STOP: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
                r_d.busy  = 1'b0;
                r_d.rx    = acc;
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (do_edge) begin
            r_d.sck   = ~r_q.sck;
            r_d.edges = edge_nx;
            if (is_sample) begin
                rx_strobe = 1'b1;
                rx_pos    = bit_pos(r_q.mode.wide, r_q.mode.lsb_first,
                                    POS_W'(r_q.edges >> 1));
            end else if (next_bit < frame_bits) begin
                r_d.mosi = r_q.tx[bit_pos(r_q.mode.wide, r_q.mode.lsb_first,
                                          POS_W'(next_bit))];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.nss_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_word = r_q.rx;
    assign busy    = r_q.busy;
    assign done    = r_q.done;
    assign sck     = r_q.sck;
    assign mosi    = r_q.mosi;
    assign nss_n   = r_q.nss_n;

    // R2
    sck_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nss_n |-> (sck == r_q.mode.cpol));

    // R3
    sck_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sck) |-> !nss_n);

    // R3
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.edges <= edge_total(r_q.mode.wide));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (nss_n && $past(nss_n) && !busy));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(r_q.tx) && $stable(r_q.mode) && $stable(r_q.div)));

endmodule

// File: tb/test_spi_master_shifter.sv
module test_spi_master_shifter;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_wide = 1'b1, cfg_lsb_first = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic [15:0] tx_word = 16'h0;
    logic [15:0] rx_word;
    logic        busy, done, sck, mosi, nss_n;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;

    // slave-side frame description
    logic        m_cpol, m_cpha, m_wide, m_lsb;
    int          m_div;
    logic [15:0] m_sw;

    // monitor state
    int          cyc = 0;
    logic        sck_prev = 1'b0;
    logic        nss_prev = 1'b1;
    int          nss_falls, nss_fall_cyc, nss_rise_cyc, edge_cnt, first_gap;
    int          last_edge_cyc, gap_err, done_cnt, done_cyc, sc, cc;
    logic        sck_at_rise, first_mosi;
    logic [15:0] cap, rx_at_done;

    always #2.5 clk = ~clk;

    spi_master_shifter #(.DIV_W(8)) i_spi_master_shifter (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_wide(cfg_wide),
        .cfg_lsb_first(cfg_lsb_first), .cfg_div(cfg_div), .tx_word(tx_word),
        .rx_word(rx_word), .busy(busy), .done(done), .sck(sck), .mosi(mosi),
        .miso(miso), .nss_n(nss_n)
    );

    function automatic int spos(input int j);
        int n;
        n = m_wide ? 16 : 8;
        return m_lsb ? j : (n - 1 - j);
    endfunction

    // Behavioural slave and timing monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (nss_prev && !nss_n) begin
            nss_falls++;
            nss_fall_cyc = cyc;
            edge_cnt = 0; gap_err = 0; cc = 0; sc = 0; cap = '0;
            first_mosi = mosi;
            if (!m_cpha) begin
                miso = m_sw[spos(0)];
                sc = 1;
            end
        end else if (!nss_prev && !nss_n && (sck != sck_prev)) begin
            edge_cnt++;
            if (edge_cnt == 1) first_gap = cyc - nss_fall_cyc;
            else if ((cyc - last_edge_cyc) != m_div + 1) gap_err++;
            last_edge_cyc = cyc;
            if ((sck != m_cpol) ^ m_cpha) begin
                if (cc < 16) cap[spos(cc)] = mosi;
                cc++;
            end else begin
                if (sc < (m_wide ? 16 : 8)) miso = m_sw[spos(sc)];
                sc++;
            end
        end
        if (!nss_prev && nss_n) begin
            nss_rise_cyc = cyc;
            sck_at_rise = sck;
        end
        if (done) begin
            done_cnt++;
            done_cyc = cyc;
            rx_at_done = rx_word;
        end
        sck_prev = sck;
        nss_prev = nss_n;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    // Runs one frame and checks every observable of it.
    task automatic do_frame(input string req, input logic cpol, input logic cpha,
                            input logic wide, input logic lsb, input int div,
                            input logic [15:0] tx, input logic [15:0] sw,
                            input bit disturb, input bit restart);
        int n;
        int waited;
        logic [15:0] exp_tx, exp_rx;
        logic exp_first;
        n = wide ? 16 : 8;
        exp_tx = wide ? tx : {8'h00, tx[7:0]};
        exp_rx = wide ? sw : {8'h00, sw[7:0]};
        exp_first = lsb ? tx[0] : (wide ? tx[15] : tx[7]);
        m_cpol = cpol; m_cpha = cpha; m_wide = wide; m_lsb = lsb; m_div = div; m_sw = sw;
        done_cnt = 0; nss_falls = 0; edge_cnt = 0;
        @(negedge clk);
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_wide = wide; cfg_lsb_first = lsb;
        cfg_div = 8'(div); tx_word = tx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "busy after start", int'(busy), 1);
        if (disturb || restart) begin
            waited = 0;
            while (edge_cnt < 3 && waited < 2000) begin settle(); waited++; end
            @(negedge clk);
            if (disturb) begin
                // R10: scramble every config input mid-frame
                cfg_cpol = ~cpol; cfg_cpha = ~cpha; cfg_wide = ~wide;
                cfg_lsb_first = ~lsb; cfg_div = 8'(div + 2); tx_word = ~tx;
            end
            if (restart) begin
                // R9: start while busy
                start = 1'b1; tx_word = 16'h0F0F; cfg_cpol = ~cpol;
                @(negedge clk);
                start = 1'b0;
            end
        end
        waited = 0;
        while (done_cnt == 0 && waited < 5000) begin settle(); waited++; end
        chk("R8", "frame completed", int'(done_cnt != 0), 1);
        repeat (20) settle();
        chk(req, "slave captured word", int'(cap), int'(exp_tx));
        chk(req, "received word at done", int'(rx_at_done), int'(exp_rx));
        chk(req, "received word held", int'(rx_word), int'(exp_rx));
        chk("R7", "bits sampled by slave", cc, n);
        chk("R3", "sck transitions", edge_cnt, 2 * n);
        chk("R3", "select to first transition", first_gap, div + 1);
        chk("R3", "half period errors", gap_err, 0);
        chk("R3", "last transition to select release", nss_rise_cyc - last_edge_cyc, div + 1);
        chk("R8", "done after select release", done_cyc - nss_rise_cyc, 1);
        chk("R8", "done pulse count", done_cnt, 1);
        chk("R8", "busy after done", int'(busy), 0);
        chk("R2", "sck at select release", int'(sck_at_rise), int'(cpol));
        chk("R2", "sck idle after frame", int'(sck), int'(cpol));
        chk("R9", "frames started", nss_falls, 1);
        if (!cpha) chk("R4", "first bit on select", int'(first_mosi), int'(exp_first));
    endtask

    task automatic t_reset();
        chk("R1", "nss_n", int'(nss_n), 1);
        chk("R1", "sck", int'(sck), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "rx_word", int'(rx_word), 0);
    endtask

    task automatic t_clock_modes();
        // R4 R5: all four polarity/phase combinations, 16-bit, top bit first
        do_frame("R4", 1'b0, 1'b0, 1'b1, 1'b0, 1, 16'hA5C3, 16'h3C96, 1'b0, 1'b0);
        do_frame("R4", 1'b0, 1'b1, 1'b1, 1'b0, 1, 16'h1234, 16'hBEEF, 1'b0, 1'b0);
        do_frame("R2", 1'b1, 1'b0, 1'b1, 1'b0, 2, 16'h8001, 16'h7FFE, 1'b0, 1'b0);
        do_frame("R5", 1'b1, 1'b1, 1'b1, 1'b0, 0, 16'hF00D, 16'h0FF1, 1'b0, 1'b0);
    endtask

    task automatic t_lsb_first();
        do_frame("R6", 1'b0, 1'b0, 1'b1, 1'b1, 1, 16'h0001, 16'h8000, 1'b0, 1'b0);
        do_frame("R6", 1'b1, 1'b1, 1'b1, 1'b1, 3, 16'hC0DE, 16'h5A17, 1'b0, 1'b0);
    endtask

    task automatic t_narrow();
        // previous frame leaves a full upper byte in rx_word
        do_frame("R5", 1'b0, 1'b0, 1'b1, 1'b0, 0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
        do_frame("R7", 1'b0, 1'b0, 1'b0, 1'b0, 0, 16'hA581, 16'hFF69, 1'b0, 1'b0);
        do_frame("R7", 1'b1, 1'b1, 1'b0, 1'b1, 2, 16'h3C0E, 16'h12B4, 1'b0, 1'b0);
    endtask

    task automatic t_start_while_busy();
        do_frame("R9", 1'b0, 1'b1, 1'b1, 1'b0, 1, 16'h6B2D, 16'h9A0C, 1'b0, 1'b1);
    endtask

    task automatic t_config_hold();
        do_frame("R10", 1'b0, 1'b0, 1'b0, 1'b0, 1, 16'h00C5, 16'h00A3, 1'b1, 1'b0);
        do_frame("R10", 1'b1, 1'b1, 1'b1, 1'b1, 0, 16'hD00B, 16'h4E21, 1'b1, 1'b0);
    endtask

    initial begin
        #(1ms);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        settle();
        t_reset();
        t_clock_modes();
        t_lsb_first();
        t_narrow();
        t_start_while_busy();
        t_config_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule